// File: doc/BRIEF.md
# Dual-Channel Match-Compare Event Timer

This block holds two independent 32-bit up-counters behind a small word-addressed register bus. Each channel has a control word that carries its enable bits and a clock divisor, a match word, and a counter that software may load. A channel that is enabled advances its counter once per divided tick. On the tick where the counter reaches the match value, the channel sets its bit in a shared status word. That bit drives the channel's interrupt output.

In use, software turns a channel off, writes zero to its counter, writes the wanted delay as the match value, and then turns the channel on with the divisor it needs. When the interrupt arrives it clears the status bit by writing a one to it. After a match the counter keeps running and wraps at 2^32, so the channel fires again only when the count next equals the match value.

Bus writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `evt_dual_timer`

## Requirements
- R1: After a synchronous active-low reset, every control, match, counter and status register reads zero and both interrupt outputs are low.
- R2: Byte offsets on the bus are control 0x00, match 0x18, counter 0x48 and status 0x60 for channel 0. Channel n sits at each of the first three offsets plus 4*n. Written values read back at their own offset, and any unmapped offset reads zero.
- R3: A channel counts when any of control bits [2:0] is one. When all three are zero its counter holds its value, whatever the upper control bits contain.
- R4: Control bits [31:16] hold a divisor d. An enabled counter advances by one every d+1 clocks, so the value k is reached k*(d+1) edges after the enabling write edge.
- R5: The divider restarts whenever the channel goes from disabled to enabled, so the first advance comes d+1 edges after the enabling write, even if the divider was stopped part way.
- R6: A write to a counter loads the written value on that edge. It takes priority over a tick in the same cycle, and writing zero restarts the count from zero.
- R7: Status bit n is set on the edge where the enabled counter of channel n advances to its match value, and it stays set until software clears it.
- R8: Writing a one to status bit n clears it, and writing zero to it has no effect. If a new match lands on the same edge as the clear, the bit stays set.
- R9: After a match the counter keeps counting, wraps from 0xFFFFFFFF to 0, and sets the flag again only on the next equality.
- R10: Interrupt output n is high only while status bit n is set and channel n is enabled. Disabling the channel masks the output but leaves the status bit readable.
- R11: Writing 0xFFFF to the status register clears every pending flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all registers and dividers |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 2 | Per-channel interrupt, bit n for channel n |

## Verification
A divider that stops at the wrong count shows up in the counter readback within one divisor period: the value read after a known number of edges is off by at least one. If the divider restart on enable is lost, the first advance comes early. The counter then reads one too high a few edges after re-enabling. A wrong compare or a wrong status update shows at `irq` on the exact edge of the expected match, and again at the wrap boundary or when a clear collides with a set. A lost mask shows as soon as a flagged channel is disabled.

// File: rtl/evt_timer_pkg.sv
// Package: shared register offsets and sizes for the dual event timer.
// Assumes byte addressing with word-aligned registers.
package evt_timer_pkg;
    localparam int unsigned OFS_CTRL   = 32'h00;
    localparam int unsigned OFS_MATCH  = 32'h18;
    localparam int unsigned OFS_COUNT  = 32'h48;
    localparam int unsigned OFS_STATUS = 32'h60;
    localparam int unsigned CH_STRIDE  = 4;
    localparam int unsigned EN_BITS    = 3;
    localparam int unsigned DIV_LSB    = 16;
endpackage

// File: rtl/evt_prescaler.sv
// Module: clock divider for one timer channel.
// Emits a one-cycle tick every (div+1) enabled clocks. The internal count
// is held at zero while disabled, so enabling always starts a full period.
// Assumes div may change at any time; a count at or above div ticks at once.
module evt_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] pre_q;

    assign tick = en && (pre_q >= div);

    // Advance the divider, restarting on tick or while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)           pre_q <= '0;
        else if (!en || tick) pre_q <= '0;
        else                  pre_q <= pre_q + 1'b1;
    end

    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (pre_q == '0)); // R5
    AST_PRE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pre_q == '0)); // R4
endmodule

// File: rtl/evt_channel.sv
// Module: one timer channel with control, match and counter registers.
// Counts divided ticks while any enable bit is set and flags a hit on the
// tick that brings the counter to the match value. A software write to the
// counter wins over a tick on the same edge and never produces a hit.
module evt_channel #(
    parameter int DATA_W  = 32,
    parameter int DIV_W   = 16,
    parameter int DIV_LSB = 16,
    parameter int EN_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              match_we,
    input  logic              count_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] match_q,
    output logic [DATA_W-1:0] count_q,
    output logic              en,
    output logic              hit
);
    logic              tick;
    logic [DATA_W-1:0] count_next;

    assign en         = |ctrl_q[EN_BITS-1:0];
    assign count_next = count_q + 1'b1;
    assign hit        = tick && !count_we && (count_next == match_q);

    // Divider that paces this channel's counter.
    evt_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .div  (ctrl_q[DIV_LSB +: DIV_W]),
        .tick (tick)
    );

    // Hold the control and match words written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            match_q <= '0;
        end else begin
            if (ctrl_we)  ctrl_q  <= wdata;
            if (match_we) match_q <= wdata;
        end
    end

    // Load the counter from the bus, otherwise advance on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)        count_q <= '0;
        else if (count_we) count_q <= wdata;
        else if (tick)     count_q <= count_next;
    end

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !count_we) |=> $stable(count_q)); // R3
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !count_we) |=> (count_q == $past(count_q) + 1'b1)); // R9
    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        count_we |=> (count_q == $past(wdata))); // R6
endmodule

// File: rtl/evt_dual_timer.sv
// Module: top of the match-compare event timer.
// Decodes the byte-addressed register bus, holds one channel instance per
// generate step, keeps the shared write-one-to-clear status word and
// drives the masked interrupt outputs. Assumes word-aligned accesses;
// any address not listed reads zero and ignores writes.
module evt_dual_timer
    import evt_timer_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(OFS_STATUS);

    logic [DATA_W-1:0] ctrl_v  [NUM_CH];
    logic [DATA_W-1:0] match_v [NUM_CH];
    logic [DATA_W-1:0] count_v [NUM_CH];
    logic [NUM_CH-1:0] en_v;
    logic [NUM_CH-1:0] hit_v;
    logic [NUM_CH-1:0] status_q;
    logic [NUM_CH-1:0] clr_v;
    logic              status_we;

    assign status_we = bus_wr && (bus_addr == STATUS_ADDR);
    assign clr_v     = status_we ? bus_wdata[NUM_CH-1:0] : '0;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(OFS_CTRL  + CH_STRIDE * n);
        localparam logic [ADDR_W-1:0] MATCH_A = ADDR_W'(OFS_MATCH + CH_STRIDE * n);
        localparam logic [ADDR_W-1:0] COUNT_A = ADDR_W'(OFS_COUNT + CH_STRIDE * n);

        evt_channel #(
            .DATA_W (DATA_W),
            .DIV_W  (DIV_W),
            .DIV_LSB(DIV_LSB),
            .EN_BITS(EN_BITS)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_we (bus_wr && (bus_addr == CTRL_A)),
            .match_we(bus_wr && (bus_addr == MATCH_A)),
            .count_we(bus_wr && (bus_addr == COUNT_A)),
            .wdata   (bus_wdata),
            .ctrl_q  (ctrl_v[n]),
            .match_q (match_v[n]),
            .count_q (count_v[n]),
            .en      (en_v[n]),
            .hit     (hit_v[n])
        );

        AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
            hit_v[n] |=> status_q[n]); // R7
        AST_STATUS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (status_q[n] && !clr_v[n]) |=> status_q[n]); // R8
        AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[n]) |-> (status_q[n] && en_v[n])); // R10
    end

    // Sticky status: new hits win over a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_v) | hit_v;
    end

    assign irq = status_q & en_v;

    // Return the addressed register, zero for unmapped offsets.
    always_comb begin
        bus_rdata = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (bus_addr == ADDR_W'(OFS_CTRL  + CH_STRIDE * n)) bus_rdata = ctrl_v[n];
            if (bus_addr == ADDR_W'(OFS_MATCH + CH_STRIDE * n)) bus_rdata = match_v[n];
            if (bus_addr == ADDR_W'(OFS_COUNT + CH_STRIDE * n)) bus_rdata = count_v[n];
        end
        if (bus_addr == STATUS_ADDR) bus_rdata = DATA_W'(status_q);
    end
endmodule

// File: tb/evt_dual_timer_bench.sv
// Bench: table of divisor/match/wait vectors for channel 0, then directed
// tests for reset, the register map, enables, restart, load priority,
// wrap, the clear rules and masking. Inputs change on the falling edge.
module evt_dual_timer_bench;
    localparam int CLK_P = 10;
    localparam int VEC_N = 6;
    // Each vector: divisor, match, edges waited, expected count, expected irq0.
    localparam int V_DIV   [VEC_N] = '{0, 0, 0, 3, 3, 2};
    localparam int V_MATCH [VEC_N] = '{5, 5, 5, 2, 2, 10};
    localparam int V_WAIT  [VEC_N] = '{4, 5, 9, 7, 8, 20};
    localparam int V_CNT   [VEC_N] = '{4, 5, 9, 1, 2, 6};
    localparam int V_IRQ   [VEC_N] = '{0, 1, 1, 0, 1, 0};

    localparam logic [7:0] A_CTRL0 = 8'h00, A_CTRL1 = 8'h04;
    localparam logic [7:0] A_MAT0  = 8'h18, A_MAT1  = 8'h1C;
    localparam logic [7:0] A_CNT0  = 8'h48, A_CNT1  = 8'h4C;
    localparam logic [7:0] A_STAT  = 8'h60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int n_checks = 0;
    int n_err = 0;
    logic [31:0] rd_v;
    logic [31:0] prev_v;

    always #(CLK_P / 2) clk = ~clk;

    evt_dual_timer u_evt_dual_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write on the next rising edge; returns at the following falling edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        edges(3);
        rst_n = 1'b1;
        edges(1);

        // R1: reset state
        rd(A_CTRL0, rd_v); check("R1 ctrl0", rd_v, 0);
        rd(A_CTRL1, rd_v); check("R1 ctrl1", rd_v, 0);
        rd(A_MAT0,  rd_v); check("R1 match0", rd_v, 0);
        rd(A_MAT1,  rd_v); check("R1 match1", rd_v, 0);
        rd(A_CNT0,  rd_v); check("R1 count0", rd_v, 0);
        rd(A_CNT1,  rd_v); check("R1 count1", rd_v, 0);
        rd(A_STAT,  rd_v); check("R1 status", rd_v, 0);
        check("R1 irq", 32'(irq), 0);

        // R2: map, stride and unmapped reads
        wr(A_CTRL1, 32'h00AB_0000);
        wr(A_MAT1,  32'h1234_5678);
        wr(A_CNT1,  32'h0000_0777);
        rd(A_CTRL1, rd_v); check("R2 ctrl1", rd_v, 32'h00AB_0000);
        rd(A_CTRL0, rd_v); check("R2 ctrl0 apart", rd_v, 0);
        rd(A_MAT1,  rd_v); check("R2 match1", rd_v, 32'h1234_5678);
        rd(A_CNT1,  rd_v); check("R2 count1", rd_v, 32'h0000_0777);
        rd(8'h10,   rd_v); check("R2 unmapped 0x10", rd_v, 0);
        rd(8'h64,   rd_v); check("R2 unmapped 0x64", rd_v, 0);

        // R4 / R7: vector table on channel 0
        for (int i = 0; i < VEC_N; i++) begin
            wr(A_CTRL0, 0);
            wr(A_STAT, 1);
            wr(A_CNT0, 0);
            wr(A_MAT0, 32'(V_MATCH[i]));
            wr(A_CTRL0, (32'(V_DIV[i]) << 16) | 32'h7);
            edges(V_WAIT[i]);
            rd(A_CNT0, rd_v); check("R4 vector count", rd_v, 32'(V_CNT[i]));
            check("R7 vector irq0", 32'(irq[0]), 32'(V_IRQ[i]));
        end

        // R3: single enable bits and hold when all clear
        wr(A_CTRL0, 0);
        wr(A_STAT, 1);
        wr(A_CNT0, 0);
        wr(A_MAT0, 32'h100);
        wr(A_CTRL0, 32'h1);
        edges(4);
        rd(A_CNT0, rd_v); check("R3 bit0 enables", rd_v, 4);
        wr(A_CTRL0, 32'h0005_0000);
        rd(A_CNT0, prev_v);
        edges(10);
        rd(A_CNT0, rd_v); check("R3 hold when off", rd_v, prev_v);
        wr(A_CTRL0, 32'h4);
        edges(3);
        rd(A_CNT0, rd_v); check("R3 bit2 enables", rd_v, prev_v + 3);

        // R5: divider restarts on re-enable
        wr(A_CTRL0, 0);
        wr(A_CNT0, 0);
        wr(A_CTRL0, 32'h0003_0007);
        edges(2);
        wr(A_CTRL0, 32'h0003_0000);
        wr(A_CTRL0, 32'h0003_0007);
        edges(3);
        rd(A_CNT0, rd_v); check("R5 no early tick", rd_v, 0);
        edges(1);
        rd(A_CNT0, rd_v); check("R5 first tick", rd_v, 1);

        // R6: load wins over tick, then counting resumes
        wr(A_CTRL0, 32'h7);
        wr(A_CNT0, 32'd100);
        rd(A_CNT0, rd_v); check("R6 load priority", rd_v, 100);
        edges(3);
        rd(A_CNT0, rd_v); check("R6 count after load", rd_v, 103);
        wr(A_CNT0, 0);
        rd(A_CNT0, rd_v); check("R6 zero restarts", rd_v, 0);

        // R8: set wins over clear, write-zero ignored, write-one clears
        wr(A_CTRL0, 0);
        wr(A_STAT, 1);
        wr(A_CNT0, 0);
        wr(A_MAT0, 3);
        wr(A_CTRL0, 32'h7);
        edges(2);
        wr(A_STAT, 1);
        rd(A_STAT, rd_v); check("R8 set wins over clear", rd_v, 1);
        wr(A_STAT, 0);
        rd(A_STAT, rd_v); check("R8 write zero ignored", rd_v, 1);
        wr(A_STAT, 2);
        rd(A_STAT, rd_v); check("R8 other bit ignored", rd_v, 1);
        wr(A_STAT, 1);
        rd(A_STAT, rd_v); check("R8 write one clears", rd_v, 0);

        // R9: wrap and match after wrap
        wr(A_CTRL0, 0);
        wr(A_CNT0, 32'hFFFF_FFFE);
        wr(A_MAT0, 1);
        wr(A_CTRL0, 32'h7);
        edges(2);
        rd(A_CNT0, rd_v); check("R9 wraps to zero", rd_v, 0);
        check("R9 no early flag", 32'(irq[0]), 0);
        edges(1);
        check("R9 flag after wrap", 32'(irq[0]), 1);
        wr(A_STAT, 1);
        edges(5);
        check("R9 no refire", 32'(irq[0]), 0);

        // R10 / R11: masking and clear-all on both channels
        wr(A_CTRL0, 0);
        wr(A_CTRL1, 0);
        wr(A_STAT, 3);
        wr(A_CNT0, 0);
        wr(A_CNT1, 0);
        wr(A_MAT0, 2);
        wr(A_MAT1, 2);
        wr(A_CTRL0, 32'h7);
        wr(A_CTRL1, 32'h7);
        edges(4);
        check("R7 both flags", 32'(irq), 3);
        wr(A_CTRL0, 0);
        check("R10 masked irq", 32'(irq), 2);
        rd(A_STAT, rd_v); check("R10 status kept", rd_v, 3);
        wr(A_CTRL0, 32'h7);
        check("R10 unmasked irq", 32'(irq), 3);
        wr(A_STAT, 32'hFFFF);
        rd(A_STAT, rd_v); check("R11 clear all status", rd_v, 0);
        check("R11 clear all irq", 32'(irq), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule